// File: doc/BRIEF.md
# Load Queue Memory Ordering Violation Detector

When a load or store finishes execution, this block walks the younger part of a circular load queue, one entry per cycle, and looks for a load whose address range overlaps the executing access. It decides whether that load broke memory ordering. A store conflicts with any overlapping load that already has a valid address. A load conflicts with an overlapping younger load only when an external snoop has hit that younger load. Otherwise the younger load is only marked as a possible violation.

The queue contents are presented on per-entry input vectors. The block holds four pieces of state: the oldest violator found so far (index and sequence number), a running violation count, and one possible-violation flag per entry. Overlap is judged on addresses shifted right by a dependency-check shift, so two accesses count as overlapping when they fall in the same aligned block of 2^SHIFT bytes. A squash input drops the held violator when the squash point is older than it. A clear input consumes the violator once the pipeline has read it.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset, busy_o, done_o and viol_vld_o are 0, viol_cnt_o is 0 and every pv_flags_o bit is 0.
- R2: An access covers blocks from addr>>DEP_SHIFT to (addr+size-1)>>DEP_SHIFT. Two accesses overlap when the executing access's last block is at least the load's first block and its first block is at most the load's last block.
- R3: The scan visits entries from start_idx_i up to, but not including, lq_tail_i (captured at start). The index wraps from LQ_DEPTH-1 to 0. When start_idx_i equals lq_tail_i, no entry is visited.
- R4: An entry whose address-valid bit is 0, or whose strictly-ordered bit is 1, is skipped. It raises no flag and yields no violation.
- R5: For an executing load (start_store_i=0), an overlapping entry with snoop bit 0 gets its pv_flags_o bit set, and the scan continues.
- R6: For an executing load, an overlapping entry with snoop bit 1 is a violation candidate, and the scan stops there.
- R7: For an executing store (start_store_i=1), any overlapping eligible entry is a violation candidate, and the scan stops there.
- R8: A candidate is recorded when no violator is held or when its sequence number is smaller than the held one. Otherwise it is discarded, and the held violator and count stay unchanged.
- R9: viol_cnt_o increments by exactly one for each recorded candidate.
- R10: squash_i with squash_seq_i smaller than the held viol_seq_o clears viol_vld_o. A squash at an equal or larger sequence number keeps it.
- R11: One entry is visited per clock. done_o is a single-cycle pulse. It rises m+1 cycles after start_i is sampled when the scan stops at the m-th visited entry, and k+2 cycles after start_i when k entries are visited without a stop.
- R12: The violator outputs hold their values until viol_clr_i clears viol_vld_o. viol_clr_i leaves viol_cnt_o unchanged.
- R13: A 1 in pv_clr_i[i] clears pv_flags_o[i] and leaves the other flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a scan (ignored while busy) |
| start_store_i | input | 1 | 1 when the executing access is a store, 0 when it is a load |
| start_addr_i | input | ADDR_W | Effective address of the executing access |
| start_size_i | input | SIZE_W | Access size in bytes (at least 1) |
| start_idx_i | input | IDX_W | First load queue index to visit |
| lq_tail_i | input | IDX_W | Load queue tail, exclusive end of the scan |
| lq_addr_i | input | LQ_DEPTH x ADDR_W | Per-entry effective address |
| lq_size_i | input | LQ_DEPTH x SIZE_W | Per-entry access size |
| lq_seq_i | input | LQ_DEPTH x SEQ_W | Per-entry sequence number |
| lq_addr_vld_i | input | LQ_DEPTH | Per-entry address-valid bit |
| lq_strict_i | input | LQ_DEPTH | Per-entry strictly-ordered bit |
| lq_snoop_i | input | LQ_DEPTH | Per-entry external snoop hit bit |
| pv_clr_i | input | LQ_DEPTH | Per-entry possible-violation flag clear |
| viol_clr_i | input | 1 | Consume and clear the held violator |
| squash_i | input | 1 | Squash strobe |
| squash_seq_i | input | SEQ_W | Squash sequence number |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle scan completion pulse |
| viol_vld_o | output | 1 | A violator is held |
| viol_idx_o | output | IDX_W | Queue index of the held violator |
| viol_seq_o | output | SEQ_W | Sequence number of the held violator |
| viol_cnt_o | output | CNT_W | Recorded violation count |
| pv_flags_o | output | LQ_DEPTH | Possible-violation flags |

## Verification
The bench builds the block with its default parameters: an eight-entry queue, a three-bit dependency shift, 32-bit addresses and 16-bit sequence numbers. With eight entries, a scan that wraps from index 6 through 7 to 0 takes only a few stimulus lines. The three-bit shift puts both outcomes of the block rule within reach: accesses a few bytes apart inside one 8-byte block overlap, and accesses on either side of a block boundary do not. The 16-bit sequence numbers allow an older entry to be planted at a higher index, which exercises the rule that keeps the oldest violator.

// File: rtl/ldq_og_pkg.sv
package ldq_og_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_st_e;
endpackage

// File: rtl/ldq_og_range.sv
module ldq_og_range #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned DEP_SHIFT = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  logic [ADDR_W-1:0] last_byte;

  always_comb begin
    last_byte = addr_i + ADDR_W'(size_i) - ADDR_W'(1);
    lo_o      = addr_i >> DEP_SHIFT;
    hi_o      = last_byte >> DEP_SHIFT;
  end
endmodule

// File: rtl/ldq_og_scan.sv
module ldq_og_scan
  import ldq_og_pkg::*;
#(
  parameter int unsigned LQ_DEPTH = 8,
  parameter int unsigned IDX_W    = $clog2(LQ_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] start_idx_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic             stop_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             exam_o,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LQ_DEPTH - 1);

  scan_st_e         st_q;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] tail_q;
  logic             done_q;
  logic [IDX_W-1:0] ptr_nxt;

  assign ptr_nxt = (ptr_q == LAST_IDX) ? '0 : ptr_q + IDX_W'(1);
  assign busy_o  = (st_q == ST_SCAN);
  assign exam_o  = busy_o && (ptr_q != tail_q);
  assign done_o  = done_q;
  assign ptr_o   = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ptr_q  <= '0;
      tail_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            st_q   <= ST_SCAN;
            ptr_q  <= start_idx_i;
            tail_q <= tail_i;
          end
        end
        ST_SCAN: begin
          if (!exam_o || stop_i) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            ptr_q <= ptr_nxt;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_start_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  p_done_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/ldq_og_viol.sv
module ldq_og_viol #(
  parameter int unsigned IDX_W = 3,
  parameter int unsigned SEQ_W = 16,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cand_i,
  input  logic [IDX_W-1:0] cand_idx_i,
  input  logic [SEQ_W-1:0] cand_seq_i,
  input  logic             clr_i,
  input  logic             squash_i,
  input  logic [SEQ_W-1:0] squash_seq_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [SEQ_W-1:0] seq_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             vld_q;
  logic [IDX_W-1:0] idx_q;
  logic [SEQ_W-1:0] seq_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;
  logic             squash_hit;

  assign accept     = cand_i && (!vld_q || (cand_seq_i < seq_q));
  assign squash_hit = squash_i && vld_q && (squash_seq_i < seq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      idx_q <= '0;
      seq_q <= '0;
      cnt_q <= '0;
    end else if (accept) begin
      vld_q <= 1'b1;
      idx_q <= cand_idx_i;
      seq_q <= cand_seq_i;
      cnt_q <= cnt_q + CNT_W'(1);
    end else if (clr_i || squash_hit) begin
      vld_q <= 1'b0;
    end
  end

  assign vld_o = vld_q;
  assign idx_o = idx_q;
  assign seq_o = seq_q;
  assign cnt_o = cnt_q;

  p_cnt_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)));
  p_keep_oldest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_i && vld_q && !(cand_seq_i < seq_q) && !clr_i && !squash_i)
    |=> vld_q && $stable(seq_q) && $stable(idx_q) && $stable(cnt_q));
  p_squash_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (squash_i && vld_q && (squash_seq_i < seq_q) && !cand_i) |=> !vld_q);
  p_clr_keeps_cnt_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cand_i) |=> !vld_q && $stable(cnt_q));
endmodule

// File: rtl/ldq_og_pv.sv
module ldq_og_pv #(
  parameter int unsigned LQ_DEPTH = 8,
  parameter int unsigned IDX_W    = 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                set_i,
  input  logic [IDX_W-1:0]    set_idx_i,
  input  logic [LQ_DEPTH-1:0] clr_i,
  input  logic                busy_i,
  output logic [LQ_DEPTH-1:0] flags_o
);
  logic [LQ_DEPTH-1:0] flag_q;

  for (genvar g = 0; g < LQ_DEPTH; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q[g] <= 1'b0;
      end else if (set_i && (set_idx_i == IDX_W'(g))) begin
        flag_q[g] <= 1'b1;
      end else if (clr_i[g]) begin
        flag_q[g] <= 1'b0;
      end
    end
  end

  assign flags_o = flag_q;

  p_pv_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && (clr_i == '0)) |=> $stable(flag_q));
  p_pv_clear_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_i && (clr_i != '0)) |=> ((flag_q & $past(clr_i)) == '0));
endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard #(
  parameter int unsigned LQ_DEPTH  = 8,
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned SIZE_W    = 4,
  parameter int unsigned SEQ_W     = 16,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned DEP_SHIFT = 3,
  parameter int unsigned IDX_W     = $clog2(LQ_DEPTH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           start_store_i,
  input  logic [ADDR_W-1:0]              start_addr_i,
  input  logic [SIZE_W-1:0]              start_size_i,
  input  logic [IDX_W-1:0]               start_idx_i,
  input  logic [IDX_W-1:0]               lq_tail_i,
  input  logic [LQ_DEPTH-1:0][ADDR_W-1:0] lq_addr_i,
  input  logic [LQ_DEPTH-1:0][SIZE_W-1:0] lq_size_i,
  input  logic [LQ_DEPTH-1:0][SEQ_W-1:0]  lq_seq_i,
  input  logic [LQ_DEPTH-1:0]            lq_addr_vld_i,
  input  logic [LQ_DEPTH-1:0]            lq_strict_i,
  input  logic [LQ_DEPTH-1:0]            lq_snoop_i,
  input  logic [LQ_DEPTH-1:0]            pv_clr_i,
  input  logic                           viol_clr_i,
  input  logic                           squash_i,
  input  logic [SEQ_W-1:0]               squash_seq_i,
  output logic                           busy_o,
  output logic                           done_o,
  output logic                           viol_vld_o,
  output logic [IDX_W-1:0]               viol_idx_o,
  output logic [SEQ_W-1:0]               viol_seq_o,
  output logic [CNT_W-1:0]               viol_cnt_o,
  output logic [LQ_DEPTH-1:0]            pv_flags_o
);
  logic              exam;
  logic [IDX_W-1:0]  ptr;
  logic              is_store_q;
  logic [ADDR_W-1:0] ilo_q, ihi_q;
  logic [ADDR_W-1:0] ilo_c, ihi_c;
  logic [ADDR_W-1:0] elo_c, ehi_c;
  logic              ent_ok, ent_ovl, ent_elig, viol_cand, pv_set;

  ldq_og_range #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEP_SHIFT(DEP_SHIFT)) u_inst_rng (
    .addr_i (start_addr_i),
    .size_i (start_size_i),
    .lo_o   (ilo_c),
    .hi_o   (ihi_c)
  );

  ldq_og_range #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DEP_SHIFT(DEP_SHIFT)) u_ent_rng (
    .addr_i (lq_addr_i[ptr]),
    .size_i (lq_size_i[ptr]),
    .lo_o   (elo_c),
    .hi_o   (ehi_c)
  );

  // executing access is frozen at start so the queue view may move underneath
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      is_store_q <= 1'b0;
      ilo_q      <= '0;
      ihi_q      <= '0;
    end else if (start_i && !busy_o) begin
      is_store_q <= start_store_i;
      ilo_q      <= ilo_c;
      ihi_q      <= ihi_c;
    end
  end

  always_comb begin
    ent_ok    = lq_addr_vld_i[ptr] && !lq_strict_i[ptr];
    ent_ovl   = (ihi_q >= elo_c) && (ilo_q <= ehi_c);
    ent_elig  = exam && ent_ok && ent_ovl;
    viol_cand = ent_elig && (is_store_q || lq_snoop_i[ptr]);
    pv_set    = ent_elig && !is_store_q && !lq_snoop_i[ptr];
  end

  ldq_og_scan #(.LQ_DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_scan (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_idx_i (start_idx_i),
    .tail_i      (lq_tail_i),
    .stop_i      (viol_cand),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .exam_o      (exam),
    .ptr_o       (ptr)
  );

  ldq_og_viol #(.IDX_W(IDX_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u_viol (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cand_i       (viol_cand),
    .cand_idx_i   (ptr),
    .cand_seq_i   (lq_seq_i[ptr]),
    .clr_i        (viol_clr_i),
    .squash_i     (squash_i),
    .squash_seq_i (squash_seq_i),
    .vld_o        (viol_vld_o),
    .idx_o        (viol_idx_o),
    .seq_o        (viol_seq_o),
    .cnt_o        (viol_cnt_o)
  );

  ldq_og_pv #(.LQ_DEPTH(LQ_DEPTH), .IDX_W(IDX_W)) u_pv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (pv_set),
    .set_idx_i (ptr),
    .clr_i     (pv_clr_i),
    .busy_i    (busy_o),
    .flags_o   (pv_flags_o)
  );

  p_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exam && !ent_ok) |=> $stable(viol_cnt_o) && busy_o);
  p_store_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exam && is_store_q && ent_ok && ent_ovl) |=> done_o);
  p_load_snoop_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exam && !is_store_q && ent_ok && ent_ovl && lq_snoop_i[ptr]) |=> done_o);
endmodule

// File: tb/ldq_order_guard_tb.sv
module ldq_order_guard_tb_top;
  localparam int DEPTH = 8;
  localparam int AW    = 32;
  localparam int SW    = 4;
  localparam int QW    = 16;
  localparam int CW    = 8;
  localparam int SH    = 3;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic                        start, start_store;
  logic [AW-1:0]               start_addr;
  logic [SW-1:0]               start_size;
  logic [IW-1:0]               start_idx, lq_tail;
  logic [DEPTH-1:0][AW-1:0]    lq_addr;
  logic [DEPTH-1:0][SW-1:0]    lq_size;
  logic [DEPTH-1:0][QW-1:0]    lq_seq;
  logic [DEPTH-1:0]            lq_vld, lq_strict, lq_snoop, pv_clr;
  logic                        viol_clr, squash;
  logic [QW-1:0]               squash_seq;
  logic                        busy, done, viol_vld;
  logic [IW-1:0]               viol_idx;
  logic [QW-1:0]               viol_seq;
  logic [CW-1:0]               viol_cnt;
  logic [DEPTH-1:0]            pv_flags;

  ldq_order_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_store_i(start_store),
    .start_addr_i(start_addr), .start_size_i(start_size), .start_idx_i(start_idx),
    .lq_tail_i(lq_tail), .lq_addr_i(lq_addr), .lq_size_i(lq_size), .lq_seq_i(lq_seq),
    .lq_addr_vld_i(lq_vld), .lq_strict_i(lq_strict), .lq_snoop_i(lq_snoop),
    .pv_clr_i(pv_clr), .viol_clr_i(viol_clr), .squash_i(squash), .squash_seq_i(squash_seq),
    .busy_o(busy), .done_o(done), .viol_vld_o(viol_vld), .viol_idx_o(viol_idx),
    .viol_seq_o(viol_seq), .viol_cnt_o(viol_cnt), .pv_flags_o(pv_flags)
  );

  typedef struct {
    logic             vld;
    logic [IW-1:0]    idx;
    logic [QW-1:0]    seq;
    logic [CW-1:0]    cnt;
    logic [DEPTH-1:0] pv;
    int               lat;
    int               t0;
    string            req;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   finished = 1'b0;

  // model of the held state, kept from the requirements
  logic             m_vld = 1'b0;
  logic [IW-1:0]    m_idx = '0;
  logic [QW-1:0]    m_seq = '0;
  logic [CW-1:0]    m_cnt = '0;
  logic [DEPTH-1:0] m_pv = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic chk_state(input string req);
    chk(viol_vld == m_vld, {req, " viol_vld"}, longint'(viol_vld), longint'(m_vld));
    if (m_vld) begin
      chk(viol_idx == m_idx, {req, " viol_idx"}, longint'(viol_idx), longint'(m_idx));
      chk(viol_seq == m_seq, {req, " viol_seq"}, longint'(viol_seq), longint'(m_seq));
    end
    chk(viol_cnt == m_cnt, {req, " viol_cnt"}, longint'(viol_cnt), longint'(m_cnt));
    chk(pv_flags == m_pv, {req, " pv_flags"}, longint'(pv_flags), longint'(m_pv));
  endtask

  // monitor: pop one expectation per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(viol_vld == e.vld, {e.req, " viol_vld"}, longint'(viol_vld), longint'(e.vld));
        if (e.vld) begin
          chk(viol_idx == e.idx, {e.req, " viol_idx"}, longint'(viol_idx), longint'(e.idx));
          chk(viol_seq == e.seq, {e.req, " viol_seq"}, longint'(viol_seq), longint'(e.seq));
        end
        chk(viol_cnt == e.cnt, {e.req, " viol_cnt"}, longint'(viol_cnt), longint'(e.cnt));
        chk(pv_flags == e.pv, {e.req, " pv_flags"}, longint'(pv_flags), longint'(e.pv));
        chk((cyc - e.t0) == e.lat, {e.req, " R11 latency"}, longint'(cyc - e.t0), longint'(e.lat));
      end
    end
  end

  task automatic clear_lq();
    for (int i = 0; i < DEPTH; i++) begin
      lq_addr[i] = '0;
      lq_size[i] = SW'(1);
      lq_seq[i]  = QW'(100 + i);
    end
    lq_vld = '0; lq_strict = '0; lq_snoop = '0;
  endtask

  task automatic set_ent(input int i, input logic [AW-1:0] a, input logic [SW-1:0] s,
                         input logic strict_b, input logic snoop_b);
    lq_addr[i] = a; lq_size[i] = s; lq_vld[i] = 1'b1;
    lq_strict[i] = strict_b; lq_snoop[i] = snoop_b;
  endtask

  // driver: compute expected outcome, push it, launch scan, wait for the monitor
  task automatic run_scan(input logic st, input logic [AW-1:0] a, input logic [SW-1:0] sz,
                          input int sidx, input int tail, input string req);
    exp_t e;
    int   p = sidx;
    int   n = 0;
    bit   stop = 1'b0;
    logic [AW-1:0] ilo, ihi, llo, lhi;
    ilo = a >> SH;
    ihi = (a + AW'(sz) - 1) >> SH;
    while (!stop && p != tail) begin
      n++;
      if (lq_vld[p] && !lq_strict[p]) begin
        llo = lq_addr[p] >> SH;
        lhi = (lq_addr[p] + AW'(lq_size[p]) - 1) >> SH;
        if (ihi >= llo && ilo <= lhi) begin
          if (st || lq_snoop[p]) begin
            stop = 1'b1;
            if (!m_vld || lq_seq[p] < m_seq) begin
              m_vld = 1'b1; m_idx = IW'(p); m_seq = lq_seq[p]; m_cnt = m_cnt + 1'b1;
            end
          end else begin
            m_pv[p] = 1'b1;
          end
        end
      end
      if (!stop) p = (p + 1) % DEPTH;
    end
    e.vld = m_vld; e.idx = m_idx; e.seq = m_seq; e.cnt = m_cnt; e.pv = m_pv;
    e.lat = stop ? n + 1 : n + 2;
    e.req = req;
    start_store = st; start_addr = a; start_size = sz;
    start_idx = IW'(sidx); lq_tail = IW'(tail);
    e.t0 = cyc;
    exp_q.push_back(e);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_squash(input logic [QW-1:0] s);
    squash = 1'b1; squash_seq = s;
    if (m_vld && s < m_seq) m_vld = 1'b0;
    @(negedge clk);
    squash = 1'b0;
  endtask

  task automatic do_clr();
    viol_clr = 1'b1; m_vld = 1'b0;
    @(negedge clk);
    viol_clr = 1'b0;
  endtask

  initial begin
    start = 0; start_store = 0; start_addr = '0; start_size = SW'(1);
    start_idx = '0; lq_tail = '0; pv_clr = '0; viol_clr = 0; squash = 0; squash_seq = '0;
    clear_lq();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 1'b0, "R1 busy", longint'(busy), 0);
    chk(done == 1'b0, "R1 done", longint'(done), 0);
    chk_state("R1");

    // R7 store hits first eligible overlap; R4 invalid entry skipped; R3 tail bound
    clear_lq();
    set_ent(2, 32'h200, 4'd4, 0, 0);
    set_ent(3, 32'h100, 4'd4, 0, 0); lq_vld[3] = 1'b0;
    set_ent(4, 32'h104, 4'd4, 0, 0);
    set_ent(5, 32'h100, 4'd8, 0, 0);
    run_scan(1'b1, 32'h100, 4'd8, 2, 6, "R7/R4 store scan");

    // R12 clear consumes violator, count kept
    do_clr();
    chk_state("R12 clear");

    // R5 load without snoop marks; R4 strict skipped; R3 entry at tail untouched
    clear_lq();
    set_ent(0, 32'h300, 4'd4, 0, 0);
    set_ent(1, 32'h302, 4'd2, 1, 1);
    set_ent(2, 32'h304, 4'd4, 0, 0);
    set_ent(3, 32'h400, 4'd4, 0, 1);
    set_ent(4, 32'h300, 4'd4, 0, 1);
    run_scan(1'b0, 32'h300, 4'd4, 0, 4, "R5/R3 load marks");

    // R6 load with snoop hit stops
    clear_lq();
    set_ent(1, 32'h500, 4'd4, 0, 0);
    set_ent(2, 32'h500, 4'd4, 0, 1);
    set_ent(3, 32'h500, 4'd4, 0, 1);
    run_scan(1'b0, 32'h500, 4'd4, 1, 5, "R6 load snoop");

    // R8 younger candidate discarded
    clear_lq();
    set_ent(5, 32'h600, 4'd4, 0, 0);
    run_scan(1'b1, 32'h600, 4'd4, 5, 7, "R8 younger discarded");

    // R9 older candidate replaces and counts
    clear_lq();
    set_ent(6, 32'h700, 4'd4, 0, 0);
    lq_seq[6] = QW'(50);
    run_scan(1'b1, 32'h700, 4'd4, 6, 7, "R9 older recorded");

    // R10 squash at or after violator keeps it; older squash clears
    do_squash(QW'(60));
    chk_state("R10 squash keep");
    do_squash(QW'(50));
    chk_state("R10 squash equal");
    do_squash(QW'(49));
    chk_state("R10 squash clear");

    // R3 wrap 6,7,0
    clear_lq();
    set_ent(6, 32'h900, 4'd4, 0, 0);
    set_ent(7, 32'h910, 4'd4, 0, 0);
    set_ent(0, 32'h800, 4'd2, 0, 0);
    run_scan(1'b1, 32'h800, 4'd2, 6, 1, "R3 wrap");

    // R3 empty range, R11 latency two
    run_scan(1'b1, 32'h800, 4'd2, 3, 3, "R3 empty");

    // R2 block granularity
    do_clr();
    clear_lq();
    set_ent(0, 32'h1008, 4'd1, 0, 0);
    set_ent(1, 32'h0FFC, 4'd5, 0, 0);
    run_scan(1'b1, 32'h1000, 4'd1, 0, 3, "R2 granularity");
    clear_lq();
    set_ent(2, 32'h2007, 4'd1, 0, 0);
    run_scan(1'b1, 32'h2000, 4'd1, 2, 3, "R2 same block");

    // R13 flag clear
    pv_clr = 8'b0000_0001;
    m_pv[0] = 1'b0;
    @(negedge clk);
    pv_clr = '0;
    chk_state("R13 pv clear");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule